// File: doc/BRIEF.md
# Packed Vector Test-Not-Mask Unit

This unit takes two packed integer vectors and produces one mask bit per element. For each element it ANDs the matching slices of the two operands. It sets the element's mask bit when that AND is entirely zero and the matching writemask bit is set. Elements may be 8, 16, 32 or 64 bits wide. The active vector length may be 128, 256 or 512 bits, so one operation yields between 2 and 64 meaningful mask bits.

For 32-bit and 64-bit elements, the second operand can be replaced by one scalar taken from its least significant element and copied into every element position. Asking for that copy with 8-bit or 16-bit elements, or giving the reserved length code, is flagged as an illegal configuration. In that case the stored mask is kept.

The result is captured in an output register one clock after an input strobe, and a one-cycle valid pulse goes with it. Instruction decode, memory operands and exception reporting are handled outside this block.

Top module: `vtnm_unit`

## Requirements
- R1: While reset is high and after it is released, before any strobe, out_valid, out_illegal and every out_mask bit are 0.
- R2: With element width W, element i occupies operand bits [i*W+W-1 : i*W], element 0 at the least significant end. Mask bit i belongs to element i. The elem_size code selects W: 0 = 8, 1 = 16, 2 = 32, 3 = 64.
- R3: For a legal operation without broadcast, out_mask bit i is 1 exactly when wmask bit i is 1 and (op_a element i AND op_b element i) is all zeros.
- R4: A mask bit whose wmask bit is 0 is always 0 after a legal operation.
- R5: The vec_len code selects the length: 0 = 128, 1 = 256, 2 = 512 bits. Mask bits at positions at or above length/W, up to bit 63, are 0 after a legal operation.
- R6: With bcast = 1 and W of 32 or 64, op_b bits [W-1:0] stand in for every element of the second operand, and the upper op_b bits have no effect.
- R7: With bcast = 1 and W of 8 or 16, out_illegal is 1 with the valid pulse, and out_mask keeps its previous value.
- R8: vec_len code 3 is reserved. It sets out_illegal with the valid pulse and leaves out_mask unchanged. A legal operation clears out_illegal.
- R9: out_valid is 1 in exactly the cycle after an in_valid cycle, and out_mask changes on that same edge. Without in_valid, out_mask holds and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 512 | First packed operand |
| op_b | input | 512 | Second packed operand or broadcast scalar source |
| elem_size | input | 2 | Element width code (0: 8, 1: 16, 2: 32, 3: 64) |
| vec_len | input | 2 | Vector length code (0: 128, 1: 256, 2: 512, 3: reserved) |
| bcast | input | 1 | Replicate the low element of op_b |
| wmask | input | 64 | Writemask, one bit per element |
| out_valid | output | 1 | One-cycle pulse when a result is registered |
| out_mask | output | 64 | Registered destination mask |
| out_illegal | output | 1 | Last operation had an illegal configuration |

## Verification
On every cycle the assertions check the strobe-to-valid timing and that the mask holds between strobes. They also check that illegal requests set the flag without disturbing the mask, that masked-off positions stay 0, and that positions beyond a 128-bit or 256-bit length stay 0. The per-element zero test, the byte layout of elements and the broadcast replication cannot be stated as simple temporal properties. Only the bench's sweeps over all width, length and broadcast combinations, with operands of varied bit density and a reference model, can show that they are correct.

// File: rtl/vtnm_pkg.sv
package vtnm_pkg;

    localparam int VEC_MAX  = 512;
    localparam int MASK_MAX = VEC_MAX / 8;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_B16 = 2'd1,
        ESZ_B32 = 2'd2,
        ESZ_B64 = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef struct packed {
        logic [MASK_MAX-1:0] mask;
        logic                illegal;
        logic                valid;
    } vtnm_res_t;

    // number of elements that one operation covers
    function automatic int active_elems(input esz_e s, input vlen_e v);
        int bits;
        bits = 128 << int'(v);
        return bits >> (3 + int'(s));
    endfunction

    // broadcast needs 32/64-bit elements; length code 3 is reserved
    function automatic logic cfg_legal(input esz_e s, input vlen_e v, input logic bc);
        return (v != VL_RSVD) && !(bc && (s == ESZ_B8 || s == ESZ_B16));
    endfunction

endpackage

// File: rtl/vtnm_bcast.sv
module vtnm_bcast #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] op_b,
    input  vtnm_pkg::esz_e   esz,
    input  logic             bcast,
    output logic [VEC_W-1:0] b_eff
);
    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    logic [VEC_W-1:0] rep32;
    logic [VEC_W-1:0] rep64;

    assign rep32 = {N32{op_b[31:0]}};
    assign rep64 = {N64{op_b[63:0]}};

    always_comb begin
        b_eff = op_b;
        if (bcast) begin
            case (esz)
                vtnm_pkg::ESZ_B32: b_eff = rep32;
                vtnm_pkg::ESZ_B64: b_eff = rep64;
                default:           b_eff = op_b;
            endcase
        end
    end
endmodule

// File: rtl/vtnm_zero_tree.sv
module vtnm_zero_tree #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0]    a,
    input  logic [VEC_W-1:0]    b,
    output logic [VEC_W/8-1:0]  z8,
    output logic [VEC_W/16-1:0] z16,
    output logic [VEC_W/32-1:0] z32,
    output logic [VEC_W/64-1:0] z64
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    logic [VEC_W-1:0] conj;
    assign conj = a & b;

    // byte level: direct reduction
    for (genvar i = 0; i < N8; i++) begin : g_b8
        assign z8[i] = ~|conj[i*8 +: 8];
    end
    // wider levels reuse the narrower zero flags
    for (genvar i = 0; i < N16; i++) begin : g_b16
        assign z16[i] = z8[2*i] & z8[2*i+1];
    end
    for (genvar i = 0; i < N32; i++) begin : g_b32
        assign z32[i] = z16[2*i] & z16[2*i+1];
    end
    for (genvar i = 0; i < N64; i++) begin : g_b64
        assign z64[i] = z32[2*i] & z32[2*i+1];
    end
endmodule

// File: rtl/vtnm_mask_gate.sv
module vtnm_mask_gate #(
    parameter int MASK_W = 64,
    parameter int CNT_W  = $clog2(MASK_W) + 1
) (
    input  logic [MASK_W-1:0] zero_sel,
    input  logic [MASK_W-1:0] wmask,
    input  logic [CNT_W-1:0]  count,
    output logic [MASK_W-1:0] result
);
    logic [MASK_W-1:0] in_range;

    for (genvar i = 0; i < MASK_W; i++) begin : g_rng
        assign in_range[i] = (CNT_W'(i) < count);
    end

    assign result = zero_sel & wmask & in_range;
endmodule

// File: rtl/vtnm_unit.sv
module vtnm_unit #(
    parameter int VEC_W  = vtnm_pkg::VEC_MAX,
    parameter int MASK_W = VEC_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  op_a,
    input  logic [VEC_W-1:0]  op_b,
    input  logic [1:0]        elem_size,
    input  logic [1:0]        vec_len,
    input  logic              bcast,
    input  logic [MASK_W-1:0] wmask,
    output logic              out_valid,
    output logic [MASK_W-1:0] out_mask,
    output logic              out_illegal
);
    import vtnm_pkg::*;

    localparam int CNT_W = $clog2(MASK_W) + 1;

    esz_e  esz;
    vlen_e vl;
    assign esz = esz_e'(elem_size);
    assign vl  = vlen_e'(vec_len);

    logic [VEC_W-1:0]    b_eff;
    logic [VEC_W/8-1:0]  z8;
    logic [VEC_W/16-1:0] z16;
    logic [VEC_W/32-1:0] z32;
    logic [VEC_W/64-1:0] z64;
    logic [MASK_W-1:0]   zero_sel;
    logic [MASK_W-1:0]   gated;
    logic [CNT_W-1:0]    count;
    logic                legal;

    vtnm_bcast #(.VEC_W(VEC_W)) i_bcast (
        .op_b  (op_b),
        .esz   (esz),
        .bcast (bcast),
        .b_eff (b_eff)
    );

    vtnm_zero_tree #(.VEC_W(VEC_W)) i_tree (
        .a   (op_a),
        .b   (b_eff),
        .z8  (z8),
        .z16 (z16),
        .z32 (z32),
        .z64 (z64)
    );

    always_comb begin
        case (esz)
            ESZ_B8:  zero_sel = MASK_W'(z8);
            ESZ_B16: zero_sel = MASK_W'(z16);
            ESZ_B32: zero_sel = MASK_W'(z32);
            default: zero_sel = MASK_W'(z64);
        endcase
    end

    assign count = CNT_W'(active_elems(esz, vl));
    assign legal = cfg_legal(esz, vl, bcast);

    vtnm_mask_gate #(.MASK_W(MASK_W), .CNT_W(CNT_W)) i_gate (
        .zero_sel (zero_sel),
        .wmask    (wmask),
        .count    (count),
        .result   (gated)
    );

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              illegal;
        logic              valid;
    } res_t;

    res_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.illegal <= !legal;
                if (legal) res_q.mask <= gated;
            end
        end
    end

    assign out_valid   = res_q.valid;
    assign out_mask    = res_q.mask;
    assign out_illegal = res_q.illegal;
endmodule

// File: rtl/vtnm_unit_chk.sv
module vtnm_unit_chk #(
    parameter int VEC_W  = 512,
    parameter int MASK_W = VEC_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        elem_size,
    input logic [1:0]        vec_len,
    input logic              bcast,
    input logic [MASK_W-1:0] wmask,
    input logic              out_valid,
    input logic [MASK_W-1:0] out_mask,
    input logic              out_illegal
);
    logic ok_cfg;
    assign ok_cfg = (vec_len != 2'd3) && !(bcast && !elem_size[1]);

    assert_strobe_valid_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_mask)));

    assert_narrow_bcast_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcast && !elem_size[1]) |=> (out_illegal && $stable(out_mask)));

    assert_rsvd_len_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len == 2'd3) |=> (out_illegal && $stable(out_mask)));

    assert_legal_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ok_cfg) |=> !out_illegal);

    assert_wmask_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ok_cfg) |=> ((out_mask & ~$past(wmask)) == '0));

    assert_range_128_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ok_cfg && vec_len == 2'd0) |=> (out_mask[MASK_W-1:MASK_W/4] == '0));

    assert_range_256_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ok_cfg && vec_len == 2'd1) |=> (out_mask[MASK_W-1:MASK_W/2] == '0));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_mask == '0));
endmodule

bind vtnm_unit vtnm_unit_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .elem_size   (elem_size),
    .vec_len     (vec_len),
    .bcast       (bcast),
    .wmask       (wmask),
    .out_valid   (out_valid),
    .out_mask    (out_mask),
    .out_illegal (out_illegal)
);

// File: tb/test_vtnm_unit.sv
module test_vtnm_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] op_a = '0;
    logic [511:0] op_b = '0;
    logic [1:0]   elem_size = '0;
    logic [1:0]   vec_len = '0;
    logic         bcast = 1'b0;
    logic [63:0]  wmask = '0;
    logic         out_valid;
    logic [63:0]  out_mask;
    logic         out_illegal;

    int n_checks = 0;
    int n_errors = 0;
    logic finished = 1'b0;
    logic [63:0] last_mask = '0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    vtnm_unit i_vtnm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .elem_size(elem_size), .vec_len(vec_len), .bcast(bcast), .wmask(wmask),
        .out_valid(out_valid), .out_mask(out_mask), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic rand64(output logic [63:0] v);
        rng = step(rng);
        v = rng;
    endtask

    task automatic rand512(input int density, output logic [511:0] v);
        logic [63:0] w;
        logic [511:0] acc;
        v = '1;
        for (int d = 0; d < density; d++) begin
            for (int k = 0; k < 8; k++) begin
                rand64(w);
                acc[k*64 +: 64] = w;
            end
            v = v & acc;
        end
    endtask

    function automatic logic [63:0] model(input logic [511:0] a, input logic [511:0] b,
                                          input int sz, input int vl, input logic bc,
                                          input logic [63:0] wm);
        int w;
        int n;
        logic [511:0] bb;
        logic [511:0] field;
        logic [63:0] r;
        w = 8 << sz;
        n = (128 << vl) / w;
        field = (512'b1 << w) - 512'b1;
        bb = b;
        if (bc) begin
            bb = '0;
            for (int i = 0; i < 512 / w; i++) bb = bb | ((b & field) << (i * w));
        end
        r = '0;
        for (int i = 0; i < n; i++)
            if (wm[i] && ((((a & bb) >> (i * w)) & field) == '0)) r[i] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [511:0] a, input logic [511:0] b,
                          input int sz, input int vl, input logic bc, input logic [63:0] wm);
        logic [63:0] exp;
        logic illegal;
        illegal = (vl == 3) || (bc && sz < 2);
        exp = illegal ? last_mask : model(a, b, sz, vl, bc, wm);
        @(negedge clk);
        op_a = a; op_b = b; elem_size = 2'(sz); vec_len = 2'(vl);
        bcast = bc; wmask = wm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", 64'(out_valid), 64'd1);
        check(req, "out_illegal", 64'(out_illegal), 64'(illegal));
        check(req, "out_mask", out_mask, exp);
        last_mask = exp;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [511:0] a;
        logic [511:0] b;
        logic [63:0] wm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while held and after release
        check("R1", "out_mask", out_mask, 64'd0);
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_illegal", 64'(out_illegal), 64'd0);
        check("R1", "out_mask after release", out_mask, 64'd0);

        // R2: single set bit in element k, other operand all ones
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < (512 >> (3 + sz)); k += 3) begin
                a = 512'b1 << (k * (8 << sz) + (8 << sz) - 1);
                run_op("R2", a, '1, sz, 2, 1'b0, '1);
            end
        end

        // R3/R6/R7: sweep width x length x broadcast with varied densities
        for (int sz = 0; sz < 4; sz++)
            for (int vl = 0; vl < 3; vl++)
                for (int bc = 0; bc < 2; bc++)
                    for (int p = 0; p < 12; p++) begin
                        rand512(1 + p % 4, a);
                        rand512(1 + (p / 4) % 3 + 1, b);
                        rand64(wm);
                        if (p == 0) wm = '1;
                        run_op(bc == 0 ? "R3" : (sz < 2 ? "R7" : "R6"),
                               a, b, sz, vl, bc[0], wm);
                    end

        // R6: upper op_b bits must not matter under broadcast
        a = '0;
        a[40] = 1'b1;
        b = '1;
        b[31:0] = 32'h0;
        run_op("R6", a, b, 2, 2, 1'b1, '1);
        b[63:0] = 64'h0;
        run_op("R6", a, b, 3, 1, 1'b1, '1);

        // R4: zero writemask gives zero mask
        run_op("R4", '0, '0, 0, 2, 1'b0, 64'd0);
        // R5: all-zero operands, full writemask: count of ones by length
        run_op("R5", '0, '0, 0, 0, 1'b0, '1);
        check("R5", "upper bits 128/8", out_mask, 64'h0000_0000_0000_FFFF);
        run_op("R5", '0, '0, 1, 1, 1'b0, '1);
        run_op("R5", '0, '0, 3, 0, 1'b0, '1);
        // R8: reserved length keeps mask, then legal op clears flag
        run_op("R8", '1, '1, 0, 3, 1'b0, '1);
        run_op("R8", '0, '0, 2, 2, 1'b0, '1);
        // R7: narrow broadcast keeps a non-zero previous mask
        run_op("R7", '0, '0, 1, 2, 1'b1, '1);

        // R9: idle cycles hold the mask with no valid pulse
        @(negedge clk);
        check("R9", "out_valid idle", 64'(out_valid), 64'd0);
        check("R9", "out_mask idle", out_mask, last_mask);
        op_a = '1; op_b = '0; wmask = '1;
        @(negedge clk);
        check("R9", "out_mask no strobe", out_mask, last_mask);

        finish_run();
    end
endmodule